// File: doc/BRIEF.md
# Register Write Command Executor

This block runs a queue of register-write instructions that software has placed in memory and applies them to a display register bus. Software turns the engine on through a small control/status interface, loads a start pointer, and then loads an end pointer. The end-pointer write starts the run. The engine fetches 64-bit instruction words one at a time from the start pointer up to the end pointer, decodes them, and issues each register write as one valid/ready transfer on its write port.

There are two instruction forms. A direct write carries its data in the same word. An indexed write carries a count of data words, and those words follow the header packed two to a word. An indexed write with an odd count leaves a zero pad in the upper half of its last word, and the engine skips it. All-zero words are no-ops, so software can pad the queue out to a cache-line boundary. The engine reports busy for the whole run. It also has a sticky error bit, which is set by a bad end pointer or by an unknown opcode.

Top module: `rwe_cmd_exec`

## Requirements
- R1: After reset the control word reads 0 (enable, busy and error all clear), and neither mem_req_o nor wr_valid_o is asserted.
- R2: A word whose bits 63:56 equal 0x01 produces one register write. Its offset is bits 51:32, its byte enables are bits 55:52 and its data is bits 31:0.
- R3: A word whose bits 63:56 equal 0x09 is an indexed header with count N in bits 31:0. The N data words that follow are all written, in order, to the offset in bits 51:32 with the byte enables in bits 55:52. Each 64-bit data word holds two data words, lower half first. When N is odd, the upper half of the last word is skipped. When N is 0, no write is issued.
- R4: An all-zero 64-bit word in header position issues no write and execution continues with the next word.
- R5: Control/status addresses are 0 for control, 1 for start pointer and 2 for end pointer. In the control word, bit 0 is enable (read/write), bit 1 is busy (read-only) and bit 2 is error. A start-pointer read returns the written value with bits 2:0 cleared. A valid end-pointer write, made while enabled and idle, fetches 8-byte words upward from the start pointer until the fetch address equals the end pointer. Busy is set for the run and then clears.
- R6: Start-pointer and end-pointer writes made while busy are ignored, and both pointers keep their values.
- R7: An end-pointer write made while enabled and idle, with bits 5:0 not zero or with a value below the start pointer, sets the error bit. No fetch and no write follow.
- R8: A header word with a non-zero opcode other than 0x01 or 0x09 sets the error bit and ends the run. No later word is fetched, and busy clears.
- R9: Each register write is exactly one transfer. Address, data and byte enables hold steady while wr_valid_o is high and wr_ready_i is low, and no fetch is requested while a write is pending.
- R10: While enable is clear, end-pointer writes are ignored. No run starts and the error bit is not set.
- R11: Writing control with bit 2 set clears the error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_we_i | input | 1 | Control/status write strobe |
| csr_addr_i | input | 2 | Control/status address (0 control, 1 start, 2 end) |
| csr_wdata_i | input | 32 | Control/status write data |
| csr_rdata_o | output | 32 | Control/status read data for csr_addr_i |
| mem_req_o | output | 1 | Instruction fetch request |
| mem_addr_o | output | AW | Fetch byte address, 8-byte aligned |
| mem_rvalid_i | input | 1 | Fetch data valid; a fetch completes when mem_req_o and this are both high |
| mem_rdata_i | input | 64 | Fetched instruction word |
| wr_valid_o | output | 1 | Register write valid |
| wr_ready_i | input | 1 | Register write ready |
| wr_addr_o | output | 20 | Register offset |
| wr_data_o | output | 32 | Register write data |
| wr_be_o | output | 4 | Register byte enables |

## Verification
The bench uses the default 32-bit address width and a 64-byte cache line. With these values the bench can build queues a few cache lines long inside a 512-byte memory model. The end-pointer check then catches offsets that are misaligned within a line, as well as lines placed below the start pointer. Fetch responses and write-ready are throttled by a pseudo-random sequence. This tests packed indexed payloads, pad skipping and write hold under backpressure. A run of forty zero-filled words keeps the engine busy long enough to try pointer writes in the middle of a run.

// File: rtl/rwe_pkg.sv
package rwe_pkg;
  localparam int OFF_W = 20;
  localparam int BE_W  = 4;
  localparam int DW    = 32;
  localparam int IW    = 64;

  localparam logic [7:0] OP_DIRECT  = 8'h01;
  localparam logic [7:0] OP_INDEXED = 8'h09;

  localparam logic [1:0] CSR_CTRL = 2'd0;
  localparam logic [1:0] CSR_HEAD = 2'd1;
  localparam logic [1:0] CSR_TAIL = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WRITE} st_e;
endpackage

// File: rtl/rwe_csr.sv
module rwe_csr import rwe_pkg::*; #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic          busy_i,
  input  logic          op_err_i,
  output logic          start_o,
  output logic [AW-1:0] head_o,
  output logic [AW-1:0] tail_o
);
  localparam int LINE_LSB = $clog2(LINE_BYTES);
  localparam int WORD_LSB = $clog2(IW / 8);

  logic          en_q, err_q;
  logic [AW-1:0] head_q, tail_q;
  logic [AW-1:0] tail_v;
  logic          tail_wr, tail_ok, tail_bad, ctrl_wr, head_wr;

  assign tail_v   = wdata_i[AW-1:0];
  assign ctrl_wr  = we_i && addr_i == CSR_CTRL;
  assign head_wr  = we_i && addr_i == CSR_HEAD && !busy_i;
  assign tail_wr  = we_i && addr_i == CSR_TAIL && en_q && !busy_i;
  assign tail_ok  = tail_v[LINE_LSB-1:0] == '0 && tail_v >= head_q;
  assign start_o  = tail_wr && tail_ok;
  assign tail_bad = tail_wr && !tail_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      err_q  <= 1'b0;
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (ctrl_wr) en_q <= wdata_i[0];
      if (op_err_i || tail_bad) err_q <= 1'b1;
      else if (ctrl_wr && wdata_i[2]) err_q <= 1'b0;
      if (head_wr) head_q <= {wdata_i[AW-1:WORD_LSB], {WORD_LSB{1'b0}}};
      if (start_o) tail_q <= tail_v;
    end
  end

  always_comb begin
    case (addr_i)
      CSR_CTRL: rdata_o = {29'd0, err_q, busy_i, en_q};
      CSR_HEAD: rdata_o = 32'(head_q);
      CSR_TAIL: rdata_o = 32'(tail_q);
      default:  rdata_o = '0;
    endcase
  end

  assign head_o = head_q;
  assign tail_o = tail_q;

  assert_head_locked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(head_q) && $stable(tail_q));
  assert_start_enabled_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> en_q && !busy_i);
  assert_err_on_op_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_err_i |=> err_q);
endmodule

// File: rtl/rwe_engine.sv
module rwe_engine import rwe_pkg::*; #(
  parameter int AW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [AW-1:0]    head_i,
  input  logic [AW-1:0]    tail_i,
  output logic             busy_o,
  output logic             op_err_o,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [IW-1:0]    mem_rdata_i,
  output logic             wr_valid_o,
  input  logic             wr_ready_i,
  output logic [OFF_W-1:0] wr_addr_o,
  output logic [DW-1:0]    wr_data_o,
  output logic [BE_W-1:0]  wr_be_o
);
  localparam int STEP = IW / 8;

  st_e              st_q;
  logic [AW-1:0]    fetch_q;
  logic [IW-1:0]    word_q;
  logic [DW-1:0]    rem_q;
  logic [OFF_W-1:0] off_q;
  logic [BE_W-1:0]  be_q;
  logic             half_q, direct_q, in_data_q;
  logic             at_end, take;
  logic [7:0]       op;

  assign at_end     = fetch_q == tail_i;
  assign mem_req_o  = st_q == ST_FETCH && !at_end;
  assign mem_addr_o = fetch_q;
  assign take       = mem_req_o && mem_rvalid_i;
  assign op         = mem_rdata_i[63:56];
  assign op_err_o   = take && !in_data_q && mem_rdata_i != '0 &&
                      op != OP_DIRECT && op != OP_INDEXED;
  assign busy_o     = st_q != ST_IDLE;
  assign wr_valid_o = st_q == ST_WRITE;
  assign wr_addr_o  = off_q;
  assign wr_be_o    = be_q;
  assign wr_data_o  = half_q ? word_q[63:32] : word_q[31:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      fetch_q   <= '0;
      word_q    <= '0;
      rem_q     <= '0;
      off_q     <= '0;
      be_q      <= '0;
      half_q    <= 1'b0;
      direct_q  <= 1'b0;
      in_data_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q      <= ST_FETCH;
          fetch_q   <= head_i;
          in_data_q <= 1'b0;
        end
        ST_FETCH: begin
          if (at_end) st_q <= ST_IDLE;
          else if (take) begin
            fetch_q <= fetch_q + AW'(STEP);
            word_q  <= mem_rdata_i;
            half_q  <= 1'b0;
            if (in_data_q) st_q <= ST_WRITE;
            else if (mem_rdata_i != '0) begin
              off_q <= mem_rdata_i[51:32];
              be_q  <= mem_rdata_i[55:52];
              if (op == OP_DIRECT) begin
                direct_q <= 1'b1;
                st_q     <= ST_WRITE;
              end else if (op == OP_INDEXED) begin
                direct_q  <= 1'b0;
                rem_q     <= mem_rdata_i[31:0];
                in_data_q <= mem_rdata_i[31:0] != '0;
              end else st_q <= ST_IDLE;
            end
          end
        end
        ST_WRITE: if (wr_ready_i) begin
          if (direct_q) st_q <= ST_FETCH;
          else begin
            rem_q <= rem_q - 1'b1;
            if (rem_q == DW'(1)) begin
              in_data_q <= 1'b0;  // pad half, if any, is dropped
              st_q      <= ST_FETCH;
            end else if (!half_q) half_q <= 1'b1;
            else st_q <= ST_FETCH;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_wr_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) &&
    $stable(wr_data_o) && $stable(wr_be_o));
  assert_no_fetch_in_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && wr_valid_o));
  assert_fetch_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[2:0] == 3'd0 && mem_addr_o < tail_i);
  assert_op_err_stops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_err_o |=> !busy_o);
endmodule

// File: rtl/rwe_cmd_exec.sv
module rwe_cmd_exec import rwe_pkg::*; #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             csr_we_i,
  input  logic [1:0]       csr_addr_i,
  input  logic [31:0]      csr_wdata_i,
  output logic [31:0]      csr_rdata_o,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [63:0]      mem_rdata_i,
  output logic             wr_valid_o,
  input  logic             wr_ready_i,
  output logic [19:0]      wr_addr_o,
  output logic [31:0]      wr_data_o,
  output logic [3:0]       wr_be_o
);
  logic          busy, op_err, start;
  logic [AW-1:0] head, tail;

  rwe_csr #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_csr (
    .clk_i, .rst_ni,
    .we_i(csr_we_i), .addr_i(csr_addr_i), .wdata_i(csr_wdata_i), .rdata_o(csr_rdata_o),
    .busy_i(busy), .op_err_i(op_err), .start_o(start), .head_o(head), .tail_o(tail)
  );

  rwe_engine #(.AW(AW)) u_engine (
    .clk_i, .rst_ni,
    .start_i(start), .head_i(head), .tail_i(tail), .busy_o(busy), .op_err_o(op_err),
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .wr_valid_o, .wr_ready_i, .wr_addr_o, .wr_data_o, .wr_be_o
  );

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mem_req_o && !wr_valid_o);
endmodule

// File: tb/rwe_cmd_exec_test.sv
`timescale 1ns/1ps
module rwe_cmd_exec_test;
  logic        clk = 0, rst_n = 0;
  logic        csr_we = 0;
  logic [1:0]  csr_addr = 0;
  logic [31:0] csr_wdata = 0, csr_rdata;
  logic        mem_req, mem_rvalid, wr_valid, wr_ready = 1, mem_ok = 1;
  logic [31:0] mem_addr, wr_data;
  logic [63:0] mem_rdata;
  logic [19:0] wr_addr;
  logic [3:0]  wr_be;
  logic [63:0] mem [0:63];
  logic [15:0] lfsr = 16'hACE1;
  bit          throttle = 0;
  int          n_chk = 0, n_bad = 0, log_n = 0, fetch_n = 0;
  logic [19:0] log_a [0:255];
  logic [31:0] log_d [0:255];
  logic [3:0]  log_b [0:255];

  always #2 clk = ~clk;

  rwe_cmd_exec uut (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(csr_we), .csr_addr_i(csr_addr),
    .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .wr_be_o(wr_be)
  );

  assign mem_rvalid = mem_req && mem_ok;
  assign mem_rdata  = mem[mem_addr[8:3]];

  // set handshake inputs for the next edge, then log what that edge will take
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ok   = throttle ? lfsr[0] : 1'b1;
    wr_ready = throttle ? lfsr[3] : 1'b1;
    if (wr_valid && wr_ready && log_n < 256) begin
      log_a[log_n] = wr_addr; log_d[log_n] = wr_data; log_b[log_n] = wr_be;
      log_n++;
    end
    if (mem_req && mem_ok) fetch_n++;
  end

  function automatic logic [63:0] ins(logic [7:0] op, logic [3:0] be, logic [19:0] off, logic [31:0] lo);
    return {op, be, off, lo};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic csr_wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); csr_we = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_we = 0;
  endtask

  task automatic csr_rd(logic [1:0] a, output logic [31:0] d);
    csr_addr = a; #1; d = csr_rdata;
  endtask

  task automatic wait_idle(string tag);
    logic [31:0] c;
    for (int i = 0; i < 3000; i++) begin
      csr_rd(0, c);
      if (!c[1]) return;
      @(negedge clk);
    end
    chk({tag, " timeout"}, 1, 0);
  endtask

  task automatic expect_wr(int idx, logic [19:0] a, logic [31:0] d, logic [3:0] b, string tag);
    chk({tag, " addr"}, log_a[idx], a);
    chk({tag, " data"}, log_d[idx], d);
    chk({tag, " be"},   log_b[idx], b);
  endtask

  task automatic t_reset;
    logic [31:0] c;
    csr_rd(0, c);
    chk("R1 ctrl", c, 0);
    chk("R1 req/valid", {mem_req, wr_valid}, 0);
  endtask

  task automatic t_direct;
    int l0 = log_n, f0 = fetch_n;
    logic [31:0] c;
    csr_wr(0, 1); csr_wr(1, 0); csr_wr(2, 64);
    wait_idle("R2");
    chk("R2 count", log_n - l0, 2);
    expect_wr(l0,     20'h00123, 32'hDEADBEEF, 4'hF, "R2 w0");
    expect_wr(l0 + 1, 20'h00456, 32'h11223344, 4'h3, "R2 w1");
    chk("R4 R5 fetches", fetch_n - f0, 8);
    csr_rd(0, c); chk("R5 busy clear", c, 1);
  endtask

  task automatic t_indexed;
    int l0 = log_n, f0 = fetch_n;
    throttle = 1;
    csr_wr(1, 64); csr_wr(2, 128);
    wait_idle("R3");
    throttle = 0;
    chk("R3 R9 count", log_n - l0, 7);
    expect_wr(l0,     20'h200, 32'h1111_0001, 4'hF, "R3 odd d1");
    expect_wr(l0 + 1, 20'h200, 32'h1111_0002, 4'hF, "R3 odd d2");
    expect_wr(l0 + 2, 20'h200, 32'h1111_0003, 4'hF, "R3 odd d3");
    expect_wr(l0 + 3, 20'h300, 32'h0000_00AA, 4'hF, "R3 pad skipped");
    expect_wr(l0 + 4, 20'h210, 32'h2222_0004, 4'hC, "R3 even d1");
    expect_wr(l0 + 5, 20'h210, 32'h2222_0005, 4'hC, "R3 even d2");
    expect_wr(l0 + 6, 20'h310, 32'h0000_0055, 4'h1, "R3 n0 then direct");
    chk("R3 fetches", fetch_n - f0, 8);
  endtask

  task automatic t_busy_lock;
    int l0 = log_n, f0 = fetch_n;
    logic [31:0] c;
    throttle = 1;
    csr_wr(1, 128); csr_wr(2, 448);
    csr_rd(0, c); chk("R5 busy set", c[1], 1);
    csr_wr(1, 32'h40); csr_wr(2, 32'h100);
    wait_idle("R6");
    throttle = 0;
    csr_rd(1, c); chk("R6 head kept", c, 128);
    csr_rd(2, c); chk("R6 tail kept", c, 448);
    chk("R6 fetches", fetch_n - f0, 40);
    chk("R4 zero no writes", log_n - l0, 0);
    csr_rd(0, c); chk("R6 no error", c, 1);
  endtask

  task automatic t_bad_tail;
    int l0 = log_n, f0 = fetch_n;
    logic [31:0] c;
    csr_wr(1, 0); csr_wr(2, 32'h44);
    csr_rd(0, c); chk("R7 misaligned err", c, 5);
    csr_wr(0, 5);
    csr_rd(0, c); chk("R11 err cleared", c, 1);
    csr_wr(1, 32'h80); csr_wr(2, 32'h40);
    repeat (4) @(negedge clk);
    csr_rd(0, c); chk("R7 below head err", c, 5);
    chk("R7 no activity", {log_n - l0, fetch_n - f0}, 0);
    csr_wr(0, 5);
  endtask

  task automatic t_bad_op;
    int l0 = log_n, f0 = fetch_n;
    logic [31:0] c;
    csr_wr(1, 448); csr_wr(2, 512);
    wait_idle("R8");
    chk("R8 writes", log_n - l0, 1);
    expect_wr(l0, 20'h400, 32'h77, 4'hF, "R8 before bad op");
    chk("R8 stop fetch", fetch_n - f0, 2);
    csr_rd(0, c); chk("R8 err idle", c, 5);
    csr_wr(0, 5);
  endtask

  task automatic t_disabled;
    int l0 = log_n, f0 = fetch_n;
    logic [31:0] c;
    csr_wr(0, 0); csr_wr(1, 0); csr_wr(2, 64);
    repeat (6) @(negedge clk);
    csr_rd(0, c); chk("R10 ctrl", c, 0);
    chk("R10 no activity", {log_n - l0, fetch_n - f0}, 0);
  endtask

  task automatic t_head_round;
    int l0 = log_n;
    logic [31:0] c;
    csr_wr(0, 1); csr_wr(1, 3);
    csr_rd(1, c); chk("R5 head rounded", c, 0);
    csr_wr(2, 64);
    wait_idle("R5");
    chk("R5 rerun count", log_n - l0, 2);
    expect_wr(l0, 20'h00123, 32'hDEADBEEF, 4'hF, "R5 rerun w0");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[0]  = ins(8'h01, 4'hF, 20'h00123, 32'hDEADBEEF);
    mem[1]  = ins(8'h01, 4'h3, 20'h00456, 32'h11223344);
    mem[8]  = ins(8'h09, 4'hF, 20'h200, 32'd3);
    mem[9]  = {32'h1111_0002, 32'h1111_0001};
    mem[10] = {32'h0, 32'h1111_0003};
    mem[11] = ins(8'h01, 4'hF, 20'h300, 32'hAA);
    mem[12] = ins(8'h09, 4'hC, 20'h210, 32'd2);
    mem[13] = {32'h2222_0005, 32'h2222_0004};
    mem[14] = ins(8'h09, 4'hF, 20'h220, 32'd0);
    mem[15] = ins(8'h01, 4'h1, 20'h310, 32'h55);
    mem[56] = ins(8'h01, 4'hF, 20'h400, 32'h77);
    mem[57] = ins(8'h05, 4'hF, 20'h404, 32'h88);
    mem[58] = ins(8'h01, 4'hF, 20'h408, 32'h99);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_indexed();
    t_busy_lock();
    t_bad_tail();
    t_bad_op();
    t_disabled();
    t_head_round();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule